// File: doc/BRIEF.md
# Interlaced field scan sequencer

This block sits beside a raster DMA timing engine that can only scan progressive frames, and lets it scan an interlaced frame as two fields in turn. The host gives a full-frame mode: active lines, total lines, vertical sync start and end, and the horizontal timing. On a start pulse the block latches this mode and derives the per-field vertical values. Each field covers half the active lines. The internal vertical sync is stretched into a long helper pulse, and the front and back porches are recomputed. All sizes are presented to the engine as value-minus-one registers.

While the engine runs, a host may post a frame base address and a line stride at any time. The block keeps that pair and drives the engine's DMA address and stride. In interlaced mode the stride is doubled, so each field fetches every other line. The lower field starts one stride further into the frame. A line-match event from the engine at a fixed mid-frame line flips the field flag. On that flip the front porch of the next field grows or shrinks by one line, and the DMA address is re-pointed at the other field. A progressive mode passes the frame timing straight through. A stop pulse drops the run controls and waits for the engine to report that the last frame has drained.

Top module: `ilfs_seq`

## Requirements
- R1: In interlaced mode, after a start pulse the rows value is (v_active>>1)-1, the vertical sync width is (v_total>>1)-2, vsync_pol_o is 0 (active high) and vsync_en_o and vfp_en_o are 1.
- R2: In interlaced mode the base front porch is (v_sync_start-v_active-5)>>1 lines when v_sync_start is at least v_active+7, and 1 line otherwise; vfp_m1_o shows the base minus one while lower_field_o is 0.
- R3: In interlaced mode the back porch is (v_total>>1)-(v_active>>1)-base front porch, floored at zero. vbp_m1_o shows it minus one and vbp_en_o is 1 when it is positive; when it is zero, vbp_m1_o is 0 and vbp_en_o is 0.
- R4: In progressive mode the vertical outputs are v_active-1, v_sync_end-v_sync_start-1, v_total-v_sync_start-1 (back porch including sync) and v_sync_start-v_active-1. Each enable is set when its span is nonzero, and vsync_pol_o follows vsync_neg_i.
- R5: In either mode the horizontal outputs are h_active-1, h_sync_end-h_sync_start-1, h_total-h_sync_start-1 and h_sync_start-h_active-1.
- R6: A line_tick_i with line_idx_i equal to MATCH_LINE (default 32) toggles lower_field_o one cycle later, only while busy and in interlaced mode. Other line indices, progressive mode and the idle state leave the flag unchanged.
- R7: In interlaced mode vfp_m1_o equals the base front-porch register plus lower_field_o, so the lower field gets one extra front-porch line.
- R8: An address write stores addr_i and stride_i as the held pair. One cycle later dma_addr_o is addr_i plus stride_i when lower_field_o is 1 in interlaced mode, and addr_i otherwise. dma_stride_o is twice stride_i in interlaced mode and stride_i in progressive mode.
- R9: On a field flip with a nonzero held address, dma_addr_o becomes the held address plus the held stride if the new flag is 1, and the held address itself if it is 0. With a zero held address, dma_addr_o is unchanged.
- R10: When an address write and a matching line tick arrive in the same cycle, the write is applied and the flag does not toggle.
- R11: A start pulse sets arm_o, auto_repeat_o and busy_o, clears lower_field_o, the held address, dma_addr_o and dma_stride_o, and latches the mode.
- R12: A stop pulse clears arm_o, auto_repeat_o and the held address the next cycle. busy_o stays 1 until a drained_i pulse.
- R13: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ilace_i | input | 1 | Mode select: 1 interlaced, 0 progressive |
| vsync_neg_i | input | 1 | Progressive vertical sync active low |
| v_active_i | input | LINE_W | Frame active lines |
| v_total_i | input | LINE_W | Frame total lines |
| v_sync_start_i | input | LINE_W | Line where vertical sync starts |
| v_sync_end_i | input | LINE_W | Line where vertical sync ends |
| h_active_i | input | LINE_W | Active pixels per line |
| h_total_i | input | LINE_W | Total pixels per line |
| h_sync_start_i | input | LINE_W | Pixel where horizontal sync starts |
| h_sync_end_i | input | LINE_W | Pixel where horizontal sync ends |
| start_i | input | 1 | Latch mode and arm the engine |
| stop_i | input | 1 | Drop arm and auto-repeat |
| drained_i | input | 1 | Engine reports the last frame has finished |
| line_tick_i | input | 1 | Engine line event |
| line_idx_i | input | LINE_W | Line number of the event |
| addr_wr_i | input | 1 | Host posts a frame address |
| addr_i | input | ADDR_W | Frame base address |
| stride_i | input | STRIDE_W | Frame line stride in bytes |
| rows_m1_o | output | LINE_W | Visible rows minus one |
| cols_m1_o | output | LINE_W | Visible columns minus one |
| vsync_w_m1_o | output | LINE_W | Vertical sync width minus one |
| hsync_w_m1_o | output | LINE_W | Horizontal sync width minus one |
| vbp_m1_o | output | LINE_W | Vertical back porch (with sync) minus one |
| hbp_m1_o | output | LINE_W | Horizontal back porch (with sync) minus one |
| vfp_m1_o | output | LINE_W | Vertical front porch minus one |
| hfp_m1_o | output | LINE_W | Horizontal front porch minus one |
| vsync_pol_o | output | 1 | Vertical sync polarity, 1 active low |
| vbp_en_o | output | 1 | Vertical back porch enable |
| vfp_en_o | output | 1 | Vertical front porch enable |
| vsync_en_o | output | 1 | Vertical sync enable |
| lower_field_o | output | 1 | Lower field flag |
| dma_addr_o | output | ADDR_W | DMA start address |
| dma_stride_o | output | STRIDE_W+1 | DMA line stride |
| arm_o | output | 1 | Engine arm control |
| auto_repeat_o | output | 1 | Engine auto-repeat control |
| busy_o | output | 1 | Running or draining |

## Verification
On every cycle, the assertions check that a flip toggles the field flag and that a colliding host write freezes it. They also check that progressive mode never moves the flag, that a start arms the engine with the flag cleared, that a stop drops the run controls, that busy holds until a drain report, and that an interlaced write doubles the stride. The porch and size arithmetic for each mode, the one-line front-porch step, the field offset of the address, and the rule that a zero held address suppresses the rewrite can only be shown by the bench's scenarios. The bench compares these against values it computes from the mode.

// File: rtl/ilfs_pkg.sv
package ilfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } run_state_e;
endpackage

// File: rtl/ilfs_vtiming.sv
module ilfs_vtiming #(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              ilace_i,
  input  logic              vsync_neg_i,
  input  logic [LINE_W-1:0] v_active_i,
  input  logic [LINE_W-1:0] v_total_i,
  input  logic [LINE_W-1:0] v_sync_start_i,
  input  logic [LINE_W-1:0] v_sync_end_i,
  input  logic [LINE_W-1:0] h_active_i,
  input  logic [LINE_W-1:0] h_total_i,
  input  logic [LINE_W-1:0] h_sync_start_i,
  input  logic [LINE_W-1:0] h_sync_end_i,
  output logic              ilace_q,
  output logic              vpol_q,
  output logic              vbp_en_q,
  output logic              vfp_en_q,
  output logic              vsync_en_q,
  output logic [LINE_W-1:0] rows_m1_q,
  output logic [LINE_W-1:0] vsw_m1_q,
  output logic [LINE_W-1:0] vbp_m1_q,
  output logic [LINE_W-1:0] fp_base_m1_q,
  output logic [LINE_W-1:0] cols_m1_q,
  output logic [LINE_W-1:0] hsw_m1_q,
  output logic [LINE_W-1:0] hbp_m1_q,
  output logic [LINE_W-1:0] hfp_m1_q
);
  localparam int SW = LINE_W + 2;
  typedef logic signed [SW-1:0] sl_t;
  localparam logic [LINE_W-1:0] ONE = LINE_W'(1);

  function automatic sl_t ext(input logic [LINE_W-1:0] v);
    return sl_t'({2'b00, v});
  endfunction

  // Base front porch of a field, in lines
  function automatic logic [LINE_W-1:0] field_front(input logic [LINE_W-1:0] vd,
                                                     input logic [LINE_W-1:0] vss);
    sl_t gap;
    gap = ext(vss) - ext(vd);
    if (gap >= sl_t'(7)) return LINE_W'((gap - sl_t'(5)) >>> 1);
    return ONE;
  endfunction

  // Field back porch before flooring, may be negative
  function automatic sl_t field_back(input logic [LINE_W-1:0] vd,
                                     input logic [LINE_W-1:0] vt,
                                     input logic [LINE_W-1:0] fp);
    return ext(vt >> 1) - ext(vd >> 1) - ext(fp);
  endfunction

  logic [LINE_W-1:0] fp0;
  sl_t               bp0;
  logic              n_pol, n_bp_en, n_fp_en, n_vs_en;
  logic [LINE_W-1:0] n_rows, n_vsw, n_vbp, n_fpb;

  always_comb begin
    fp0 = field_front(v_active_i, v_sync_start_i);
    bp0 = field_back(v_active_i, v_total_i, fp0);
    if (ilace_i) begin
      n_rows  = (v_active_i >> 1) - ONE;
      n_vsw   = (v_total_i >> 1) - LINE_W'(2);
      n_bp_en = (bp0 > sl_t'(0));
      n_vbp   = n_bp_en ? LINE_W'(bp0 - sl_t'(1)) : '0;
      n_fpb   = fp0 - ONE;
      n_fp_en = 1'b1;
      n_vs_en = 1'b1;
      n_pol   = 1'b0;
    end else begin
      n_rows  = v_active_i - ONE;
      n_vsw   = v_sync_end_i - v_sync_start_i - ONE;
      n_vbp   = v_total_i - v_sync_start_i - ONE;
      n_fpb   = v_sync_start_i - v_active_i - ONE;
      n_bp_en = (v_total_i != v_sync_start_i);
      n_fp_en = (v_sync_start_i != v_active_i);
      n_vs_en = (v_sync_end_i != v_sync_start_i);
      n_pol   = vsync_neg_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ilace_q      <= 1'b0;
      vpol_q       <= 1'b0;
      vbp_en_q     <= 1'b0;
      vfp_en_q     <= 1'b0;
      vsync_en_q   <= 1'b0;
      rows_m1_q    <= '0;
      vsw_m1_q     <= '0;
      vbp_m1_q     <= '0;
      fp_base_m1_q <= '0;
      cols_m1_q    <= '0;
      hsw_m1_q     <= '0;
      hbp_m1_q     <= '0;
      hfp_m1_q     <= '0;
    end else if (load_i) begin
      ilace_q      <= ilace_i;
      vpol_q       <= n_pol;
      vbp_en_q     <= n_bp_en;
      vfp_en_q     <= n_fp_en;
      vsync_en_q   <= n_vs_en;
      rows_m1_q    <= n_rows;
      vsw_m1_q     <= n_vsw;
      vbp_m1_q     <= n_vbp;
      fp_base_m1_q <= n_fpb;
      cols_m1_q    <= h_active_i - ONE;
      hsw_m1_q     <= h_sync_end_i - h_sync_start_i - ONE;
      hbp_m1_q     <= h_total_i - h_sync_start_i - ONE;
      hfp_m1_q     <= h_sync_start_i - h_active_i - ONE;
    end
  end
endmodule

// File: rtl/ilfs_field_flip.sv
module ilfs_field_flip #(
  parameter int LINE_W     = 12,
  parameter int ADDR_W     = 40,
  parameter int STRIDE_W   = 16,
  parameter int MATCH_LINE = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                running_i,
  input  logic                ilace_i,
  input  logic                line_tick_i,
  input  logic [LINE_W-1:0]   line_idx_i,
  input  logic                addr_wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [LINE_W-1:0]   fp_base_m1_i,
  output logic                match_evt_o,
  output logic                flip_evt_o,
  output logic                lower_q,
  output logic [ADDR_W-1:0]   dma_addr_q,
  output logic [STRIDE_W:0]   dma_stride_q,
  output logic [LINE_W-1:0]   vfp_m1_o
);
  logic [ADDR_W-1:0]   held_addr;
  logic [STRIDE_W-1:0] held_stride;

  function automatic logic [ADDR_W-1:0] field_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [STRIDE_W-1:0] step,
                                                   input logic lower);
    return lower ? base + ADDR_W'(step) : base;
  endfunction

  assign match_evt_o = line_tick_i && (line_idx_i == LINE_W'(MATCH_LINE));
  // A host write in the same cycle wins over the flip
  assign flip_evt_o  = match_evt_o && running_i && ilace_i && !addr_wr_i;
  assign vfp_m1_o    = fp_base_m1_i + LINE_W'(lower_q & ilace_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lower_q      <= 1'b0;
      held_addr    <= '0;
      held_stride  <= '0;
      dma_addr_q   <= '0;
      dma_stride_q <= '0;
    end else if (start_i) begin
      lower_q      <= 1'b0;
      held_addr    <= '0;
      held_stride  <= '0;
      dma_addr_q   <= '0;
      dma_stride_q <= '0;
    end else begin
      if (flip_evt_o) begin
        lower_q <= ~lower_q;
        if (held_addr != '0)
          dma_addr_q <= field_addr(held_addr, held_stride, ~lower_q);
      end
      if (stop_i) begin
        held_addr <= '0;
      end else if (addr_wr_i) begin
        held_addr    <= addr_i;
        held_stride  <= stride_i;
        dma_addr_q   <= field_addr(addr_i, stride_i, ilace_i && lower_q);
        dma_stride_q <= ilace_i ? {stride_i, 1'b0} : {1'b0, stride_i};
      end
    end
  end
endmodule

// File: rtl/ilfs_run_ctrl.sv
module ilfs_run_ctrl
  import ilfs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic drained_i,
  output logic arm_o,
  output logic auto_repeat_o,
  output logic busy_o
);
  run_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (start_i)                                  state_d = ST_RUN;
    else if (stop_i && state_q == ST_RUN)         state_d = ST_DRAIN;
    else if (drained_i && state_q == ST_DRAIN)    state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign arm_o         = (state_q == ST_RUN);
  assign auto_repeat_o = (state_q == ST_RUN);
  assign busy_o        = (state_q != ST_IDLE);
endmodule

// File: rtl/ilfs_seq.sv
module ilfs_seq #(
  parameter int LINE_W     = 12,
  parameter int ADDR_W     = 40,
  parameter int STRIDE_W   = 16,
  parameter int MATCH_LINE = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ilace_i,
  input  logic                vsync_neg_i,
  input  logic [LINE_W-1:0]   v_active_i,
  input  logic [LINE_W-1:0]   v_total_i,
  input  logic [LINE_W-1:0]   v_sync_start_i,
  input  logic [LINE_W-1:0]   v_sync_end_i,
  input  logic [LINE_W-1:0]   h_active_i,
  input  logic [LINE_W-1:0]   h_total_i,
  input  logic [LINE_W-1:0]   h_sync_start_i,
  input  logic [LINE_W-1:0]   h_sync_end_i,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                drained_i,
  input  logic                line_tick_i,
  input  logic [LINE_W-1:0]   line_idx_i,
  input  logic                addr_wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [STRIDE_W-1:0] stride_i,
  output logic [LINE_W-1:0]   rows_m1_o,
  output logic [LINE_W-1:0]   cols_m1_o,
  output logic [LINE_W-1:0]   vsync_w_m1_o,
  output logic [LINE_W-1:0]   hsync_w_m1_o,
  output logic [LINE_W-1:0]   vbp_m1_o,
  output logic [LINE_W-1:0]   hbp_m1_o,
  output logic [LINE_W-1:0]   vfp_m1_o,
  output logic [LINE_W-1:0]   hfp_m1_o,
  output logic                vsync_pol_o,
  output logic                vbp_en_o,
  output logic                vfp_en_o,
  output logic                vsync_en_o,
  output logic                lower_field_o,
  output logic [ADDR_W-1:0]   dma_addr_o,
  output logic [STRIDE_W:0]   dma_stride_o,
  output logic                arm_o,
  output logic                auto_repeat_o,
  output logic                busy_o
);
  // Named internal events, observed by the checker
  logic              ilace_q;
  logic [LINE_W-1:0] fp_base_m1;
  logic              match_evt;
  logic              flip_evt;

  ilfs_vtiming #(.LINE_W(LINE_W)) u_vtiming (
    .clk            (clk),
    .rst_n          (rst_n),
    .load_i         (start_i),
    .ilace_i        (ilace_i),
    .vsync_neg_i    (vsync_neg_i),
    .v_active_i     (v_active_i),
    .v_total_i      (v_total_i),
    .v_sync_start_i (v_sync_start_i),
    .v_sync_end_i   (v_sync_end_i),
    .h_active_i     (h_active_i),
    .h_total_i      (h_total_i),
    .h_sync_start_i (h_sync_start_i),
    .h_sync_end_i   (h_sync_end_i),
    .ilace_q        (ilace_q),
    .vpol_q         (vsync_pol_o),
    .vbp_en_q       (vbp_en_o),
    .vfp_en_q       (vfp_en_o),
    .vsync_en_q     (vsync_en_o),
    .rows_m1_q      (rows_m1_o),
    .vsw_m1_q       (vsync_w_m1_o),
    .vbp_m1_q       (vbp_m1_o),
    .fp_base_m1_q   (fp_base_m1),
    .cols_m1_q      (cols_m1_o),
    .hsw_m1_q       (hsync_w_m1_o),
    .hbp_m1_q       (hbp_m1_o),
    .hfp_m1_q       (hfp_m1_o)
  );

  ilfs_run_ctrl u_run (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .stop_i        (stop_i),
    .drained_i     (drained_i),
    .arm_o         (arm_o),
    .auto_repeat_o (auto_repeat_o),
    .busy_o        (busy_o)
  );

  ilfs_field_flip #(
    .LINE_W     (LINE_W),
    .ADDR_W     (ADDR_W),
    .STRIDE_W   (STRIDE_W),
    .MATCH_LINE (MATCH_LINE)
  ) u_flip (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .running_i    (busy_o),
    .ilace_i      (ilace_q),
    .line_tick_i  (line_tick_i),
    .line_idx_i   (line_idx_i),
    .addr_wr_i    (addr_wr_i),
    .addr_i       (addr_i),
    .stride_i     (stride_i),
    .fp_base_m1_i (fp_base_m1),
    .match_evt_o  (match_evt),
    .flip_evt_o   (flip_evt),
    .lower_q      (lower_field_o),
    .dma_addr_q   (dma_addr_o),
    .dma_stride_q (dma_stride_o),
    .vfp_m1_o     (vfp_m1_o)
  );
endmodule

// File: rtl/ilfs_seq_chk.sv
module ilfs_seq_chk #(
  parameter int STRIDE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                stop_i,
  input logic                drained_i,
  input logic                addr_wr_i,
  input logic [STRIDE_W-1:0] stride_i,
  input logic                ilace_q,
  input logic                match_evt,
  input logic                flip_evt,
  input logic                lower_field_o,
  input logic [STRIDE_W:0]   dma_stride_o,
  input logic                arm_o,
  input logic                auto_repeat_o,
  input logic                busy_o
);
  assert_flip_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flip_evt && !start_i |=> lower_field_o != $past(lower_field_o));

  assert_prog_no_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ilace_q && !start_i |=> $stable(lower_field_o));

  assert_host_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr_i && match_evt && !start_i |=> $stable(lower_field_o));

  assert_stride_double_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr_i && ilace_q && !stop_i && !start_i |=> dma_stride_o == {$past(stride_i), 1'b0});

  assert_start_arm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> arm_o && auto_repeat_o && busy_o && !lower_field_o);

  assert_stop_quiesce_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !start_i |=> !arm_o && !auto_repeat_o);

  assert_busy_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !arm_o && !drained_i && !start_i |=> busy_o);
endmodule

bind ilfs_seq ilfs_seq_chk #(.STRIDE_W(STRIDE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .stop_i        (stop_i),
  .drained_i     (drained_i),
  .addr_wr_i     (addr_wr_i),
  .stride_i      (stride_i),
  .ilace_q       (ilace_q),
  .match_evt     (match_evt),
  .flip_evt      (flip_evt),
  .lower_field_o (lower_field_o),
  .dma_stride_o  (dma_stride_o),
  .arm_o         (arm_o),
  .auto_repeat_o (auto_repeat_o),
  .busy_o        (busy_o)
);

// File: tb/test_ilfs_seq.sv
module test_ilfs_seq;
  localparam int LW = 12;
  localparam int AW = 40;
  localparam int SW = 16;

  typedef struct packed {
    logic          il;
    logic          neg;
    logic [LW-1:0] vd;
    logic [LW-1:0] vt;
    logic [LW-1:0] vss;
    logic [LW-1:0] vse;
  } mode_t;

  localparam int NMODES = 5;
  localparam mode_t MODES [NMODES] = '{
    '{1'b1, 1'b0, 12'd1080, 12'd1125, 12'd1084, 12'd1094},  // narrow gap, fp = 1
    '{1'b1, 1'b0, 12'd480,  12'd525,  12'd490,  12'd496},   // wide gap
    '{1'b1, 1'b0, 12'd480,  12'd483,  12'd490,  12'd492},   // back porch floors at 0
    '{1'b0, 1'b1, 12'd720,  12'd750,  12'd725,  12'd730},   // progressive
    '{1'b0, 1'b0, 12'd600,  12'd628,  12'd600,  12'd604}    // progressive, no front porch
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ilace, vneg, start, stop, drained, ltick, awr;
  logic [LW-1:0] vd, vt, vss, vse, hd, ht, hss, hse, lidx;
  logic [AW-1:0] addr;
  logic [SW-1:0] stride;
  logic [LW-1:0] rows_m1, cols_m1, vsw_m1, hsw_m1, vbp_m1, hbp_m1, vfp_m1, hfp_m1;
  logic vpol, vbp_en, vfp_en, vs_en, lower, arm, arep, busy;
  logic [AW-1:0] dma_addr;
  logic [SW:0]   dma_stride;

  int nchecks = 0;
  int nfails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  ilfs_seq i_ilfs_seq (
    .clk(clk), .rst_n(rst_n), .ilace_i(ilace), .vsync_neg_i(vneg),
    .v_active_i(vd), .v_total_i(vt), .v_sync_start_i(vss), .v_sync_end_i(vse),
    .h_active_i(hd), .h_total_i(ht), .h_sync_start_i(hss), .h_sync_end_i(hse),
    .start_i(start), .stop_i(stop), .drained_i(drained),
    .line_tick_i(ltick), .line_idx_i(lidx),
    .addr_wr_i(awr), .addr_i(addr), .stride_i(stride),
    .rows_m1_o(rows_m1), .cols_m1_o(cols_m1), .vsync_w_m1_o(vsw_m1),
    .hsync_w_m1_o(hsw_m1), .vbp_m1_o(vbp_m1), .hbp_m1_o(hbp_m1),
    .vfp_m1_o(vfp_m1), .hfp_m1_o(hfp_m1), .vsync_pol_o(vpol),
    .vbp_en_o(vbp_en), .vfp_en_o(vfp_en), .vsync_en_o(vs_en),
    .lower_field_o(lower), .dma_addr_o(dma_addr), .dma_stride_o(dma_stride),
    .arm_o(arm), .auto_repeat_o(arep), .busy_o(busy)
  );

  task automatic check(input string req, input longint act, input longint exp);
    nchecks++;
    if (act != exp) begin
      nfails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_start(input mode_t m);
    ilace = m.il; vneg = m.neg; vd = m.vd; vt = m.vt; vss = m.vss; vse = m.vse;
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic match_line(input int idx);
    ltick = 1'b1; lidx = LW'(idx); tick(); ltick = 1'b0;
  endtask

  task automatic post(input longint a, input int s);
    awr = 1'b1; addr = AW'(a); stride = SW'(s); tick(); awr = 1'b0;
  endtask

  // Expected vertical values, computed from the requirements in plain integers
  task automatic check_mode(input mode_t m);
    int rows, vsw, vbp, fpb, fp, bp, gap;
    bit ebp, efp, evs, pol;
    if (m.il) begin
      gap = int'(m.vss) - int'(m.vd);
      fp  = (gap >= 7) ? (gap - 5) / 2 : 1;
      bp  = int'(m.vt) / 2 - int'(m.vd) / 2 - fp;
      if (bp < 0) bp = 0;
      rows = int'(m.vd) / 2 - 1;  vsw = int'(m.vt) / 2 - 2;
      vbp  = (bp > 0) ? bp - 1 : 0; fpb = fp - 1;
      ebp = (bp > 0); efp = 1'b1; evs = 1'b1; pol = 1'b0;
      check("R1 rows", rows_m1, rows);
      check("R1 vsync width", vsw_m1, vsw);
      check("R1 polarity/enables", {vpol, vfp_en, vs_en}, {pol, efp, evs});
      check("R2 front porch", vfp_m1, fpb);
      check("R3 back porch", vbp_m1, vbp);
      check("R3 back porch enable", vbp_en, ebp);
    end else begin
      rows = int'(m.vd) - 1; vsw = int'(m.vse) - int'(m.vss) - 1;
      vbp  = int'(m.vt) - int'(m.vss) - 1; fpb = (int'(m.vss) - int'(m.vd) - 1) & 4095;
      ebp = (m.vt != m.vss); efp = (m.vss != m.vd); evs = (m.vse != m.vss); pol = m.neg;
      check("R4 rows", rows_m1, rows);
      check("R4 vsync width", vsw_m1, vsw);
      check("R4 back porch", vbp_m1, vbp);
      check("R4 front porch", vfp_m1, fpb);
      check("R4 enables/polarity", {vbp_en, vfp_en, vs_en, vpol}, {ebp, efp, evs, pol});
    end
    check("R5 horizontal", {cols_m1, hsw_m1, hbp_m1, hfp_m1},
          {LW'(int'(hd) - 1), LW'(int'(hse) - int'(hss) - 1),
           LW'(int'(ht) - int'(hss) - 1), LW'(int'(hss) - int'(hd) - 1)});
    check("R11 armed after start", {arm, arep, busy, lower}, 4'b1110);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfails++; nchecks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
      $finish;
    end
  end

  initial begin
    ilace = 0; vneg = 0; start = 0; stop = 0; drained = 0; ltick = 0; awr = 0;
    vd = 0; vt = 0; vss = 0; vse = 0; lidx = 0; addr = 0; stride = 0;
    hd = 12'd720; ht = 12'd858; hss = 12'd736; hse = 12'd798;
    tick(); tick();
    check("R13 reset controls", {arm, arep, busy, lower}, 4'b0000);
    check("R13 reset address", dma_addr, 0);
    check("R13 reset timing", {rows_m1, vfp_m1, vbp_m1}, 0);
    rst_n = 1'b1; tick();

    for (int k = 0; k < NMODES; k++) begin
      do_start(MODES[k]);
      check_mode(MODES[k]);
    end

    // Interlaced field flipping on the 480-line mode: base fp_m1 = 1
    do_start(MODES[1]);
    post(64'h1000, 'h780);
    check("R8 address upper field", dma_addr, 64'h1000);
    check("R8 stride doubled", dma_stride, 'hF00);
    match_line(31);
    check("R6 other line ignored", lower, 0);
    match_line(32);
    check("R6 flip to lower", lower, 1);
    check("R7 front porch plus one", vfp_m1, 2);
    check("R9 lower field address", dma_addr, 64'h1780);
    match_line(32);
    check("R6 flip back", lower, 0);
    check("R9 upper field address", dma_addr, 64'h1000);
    check("R7 front porch base", vfp_m1, 1);
    match_line(32);
    // Collision: host write wins, flag stays 1
    awr = 1'b1; addr = AW'(64'h8000); stride = SW'('h100);
    ltick = 1'b1; lidx = LW'(32);
    tick(); awr = 1'b0; ltick = 1'b0;
    check("R10 flag held on collision", lower, 1);
    check("R8 write in lower field", dma_addr, 64'h8100);
    check("R8 stride after collision", dma_stride, 'h200);
    match_line(32);
    check("R9 flip after collision", dma_addr, 64'h8000);

    // Stop and drain
    stop = 1'b1; tick(); stop = 1'b0;
    check("R12 stop drops run controls", {arm, arep, busy}, 3'b001);
    match_line(32);
    check("R9 zero held address: flag still flips", lower, 1);
    check("R9 zero held address: no rewrite", dma_addr, 64'h8000);
    tick();
    check("R12 busy until drained", busy, 1);
    drained = 1'b1; tick(); drained = 1'b0;
    check("R12 idle after drain", busy, 0);
    match_line(32);
    check("R6 idle ignores match", lower, 1);

    // Progressive mode
    do_start(MODES[3]);
    check("R11 start clears flag and address", {lower, dma_addr}, 0);
    post(64'h2000, 'h500);
    check("R8 progressive stride", dma_stride, 'h500);
    check("R8 progressive address", dma_addr, 64'h2000);
    match_line(32);
    check("R6 progressive ignores match", lower, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
    $finish;
  end
endmodule